// File: doc/BRIEF.md
# DMA Stream Double-Buffer Sequencer

This block sequences the addresses and item count for one stream of a DMA channel. Software sets it up through a small register write port: a configuration word, an item count, a peripheral base and two memory bases. Once the stream is enabled, the data mover raises `itemReq` for each item it is ready to move. The sequencer answers in the same cycle with `itemDone`, together with the memory and peripheral byte addresses for that item, and then moves its count and address offsets on by one item.

The stream runs in one of three modes. In single-buffer mode it stops when the count runs out. In circular mode it reloads the count and the address offsets and carries on. In double-buffer mode it behaves like circular mode and, in addition, swaps between the two memory bases at each end of transfer. While the stream runs, software may rewrite only the memory base that is not in use. A write to the base in use is refused: it raises the error flag and stops the stream.

At enable time the sequencer checks the item count against the burst settings. A count that cannot be split evenly into whole bursts is flagged and the stream does not start.

Top module: `dma_dbuf_seq`

## Requirements
- R1: After reset `streamOn`, `tcFlag`, `errFlag`, `cfgErrFlag`, `curTarget` and `itemsLeft` are all 0.
- R2: Register select 0 is the configuration word. Its bits are: 0 enable, 1 circular, 2 double-buffer, 3 starting target, 4 memory increment, 5 peripheral increment, 7:6 memory item size, 9:8 peripheral item size, 11:10 memory burst, 13:12 peripheral burst. Item sizes are encoded 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = reserved. Burst codes are 0 = single, 1 = 4 beats, 2 = 8 beats, 3 = 16 beats. Select 1 holds the item count, select 2 the peripheral base, select 3 memory base 0 and select 4 memory base 1. Writing the configuration word with bit 0 set while idle starts the stream, provided the configuration is legal. Starting loads `itemsLeft` from the count register, loads `curTarget` from bit 3 and clears both address offsets.
- R3: While the stream runs, `itemDone` equals `itemReq` in the same cycle, and `itemDone` is never 1 while the stream is stopped. `memAddr` is the active base (memory base 1 when `curTarget` is 1) plus an offset. `perAddr` is the peripheral base plus an offset. After each item, `itemsLeft` drops by 1 and each offset grows by its item size in bytes if its increment bit is set.
- R4: With neither circular nor double-buffer set, the item that takes `itemsLeft` from 1 to 0 sets `tcFlag` and clears `streamOn`.
- R5: With circular set, that item sets `tcFlag`, reloads `itemsLeft` from the count register and resets both offsets to 0, and the stream keeps running.
- R6: With double-buffer set, the stream behaves as in R5 whatever the circular bit holds, and `curTarget` also toggles. The peripheral offset resets but the peripheral base does not change.
- R7: While the stream runs, a write to the base that is not in use (base 1 when `curTarget` is 0, base 0 when it is 1) takes effect and raises no error.
- R8: While the stream runs, a write to the base in use sets `errFlag` and clears `streamOn`. The written value is discarded.
- R9: In circular or double-buffer mode with a memory burst selected, the count must be a multiple of the burst beats times the memory item bytes divided by the peripheral item bytes. Otherwise the enable write sets `cfgErrFlag` and the stream stays stopped. Single-buffer mode skips this rule.
- R10: In circular or double-buffer mode with a peripheral burst selected, the count must be a multiple of the burst beats times the peripheral item bytes. Otherwise the enable write is refused as in R9.
- R11: A count of 0, or a reserved item size, makes an enable write set `cfgErrFlag` and leaves the stream stopped.
- R12: While the stream runs, writes to selects 1 and 2 have no effect, and neither does a configuration write with bit 0 set. A configuration write with bit 0 clear stops the stream.
- R13: A write to select 5 clears `tcFlag` where data bit 0 is 1, `errFlag` where bit 1 is 1 and `cfgErrFlag` where bit 2 is 1. Other flags are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 3 | Register select |
| wrData | input | ADDR_W | Register write data |
| itemReq | input | 1 | Data mover is ready to move one item |
| itemDone | output | 1 | Item accepted this cycle |
| memAddr | output | ADDR_W | Memory byte address of the current item |
| perAddr | output | ADDR_W | Peripheral byte address of the current item |
| itemsLeft | output | CNT_W | Items left in the current transfer |
| curTarget | output | 1 | Memory base in use (0 or 1) |
| streamOn | output | 1 | Stream enabled |
| tcFlag | output | 1 | Transfer-complete flag |
| errFlag | output | 1 | Transfer-error flag (write to the base in use) |
| cfgErrFlag | output | 1 | Enable refused because of an illegal configuration |

## Verification
The bench aims at the end-of-transfer cycle in each mode, because that is where the design does the most at once. A design that toggled the target in circular mode, or failed to reset the offsets, would send the next item to the wrong buffer or past the end of it. It also rewrites bases while the stream runs, picking both the base in use and the idle one. A design with the test inverted would either lose a legal update or corrupt the buffer being filled, and the bench checks that a refused value never reaches `memAddr`. Burst-multiple counts are probed on both sides of the rule and in single-buffer mode, which exempts them. A design that started on a bad count, or rejected a legal single-buffer count, shows up in `streamOn` and `cfgErrFlag`.

// File: rtl/dma_dbuf_pkg.sv
`timescale 1ns/1ps
package dma_dbuf_pkg;

  localparam logic [2:0] SEL_CONFIG  = 3'd0;
  localparam logic [2:0] SEL_COUNT   = 3'd1;
  localparam logic [2:0] SEL_PADDR   = 3'd2;
  localparam logic [2:0] SEL_MBASE0  = 3'd3;
  localparam logic [2:0] SEL_MBASE1  = 3'd4;
  localparam logic [2:0] SEL_FLAGCLR = 3'd5;

  typedef struct packed {
    logic       circ;
    logic       dbl;
    logic       memInc;
    logic       perInc;
    logic [1:0] memSize;
    logic [1:0] perSize;
    logic [1:0] memBurst;
    logic [1:0] perBurst;
  } cfg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // stream start: reload count, clear offsets
    logic step;     // one item accepted
    logic endXfer;  // this item finishes the transfer
    logic reload;   // wrap around at end of transfer
    logic swap;     // toggle target at end of transfer
  } strobe_t;

  function automatic cfg_t cfgDecode(logic [13:0] w);
    cfg_t c;
    c.circ     = w[1];
    c.dbl      = w[2];
    c.memInc   = w[4];
    c.perInc   = w[5];
    c.memSize  = w[7:6];
    c.perSize  = w[9:8];
    c.memBurst = w[11:10];
    c.perBurst = w[13:12];
    return c;
  endfunction

  function automatic logic [2:0] sizeBytes(logic [1:0] e);
    case (e)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [4:0] burstBeats(logic [1:0] e);
    case (e)
      2'd1:    return 5'd4;
      2'd2:    return 5'd8;
      2'd3:    return 5'd16;
      default: return 5'd1;
    endcase
  endfunction

  // count legality: units are powers of two, so multiples are a low-bit test
  function automatic logic cfgLegal(cfg_t c, logic [6:0] nLow, logic nZero);
    logic [8:0] memUnit;
    logic [8:0] perUnit;
    logic [8:0] nExt;
    logic       ok;
    nExt    = {2'b00, nLow};
    memUnit = ({4'd0, burstBeats(c.memBurst)} << c.memSize) >> c.perSize;
    perUnit = {4'd0, burstBeats(c.perBurst)} << c.perSize;
    ok = !nZero && (c.memSize != 2'd3) && (c.perSize != 2'd3);
    if (c.circ || c.dbl) begin
      if (c.memBurst != 2'd0 && (nExt & (memUnit - 9'd1)) != 9'd0) ok = 1'b0;
      if (c.perBurst != 2'd0 && (nExt & (perUnit - 9'd1)) != 9'd0) ok = 1'b0;
    end
    return ok;
  endfunction

endpackage

// File: rtl/dma_dbuf_ctrl.sv
`timescale 1ns/1ps
module dma_dbuf_ctrl
  import dma_dbuf_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [2:0]       wrSel,
  input  logic [13:0]      wrBits,
  input  logic             itemReq,
  input  logic             modeCirc,
  input  logic             modeDbl,
  input  logic             curTarget,
  input  logic [CNT_W-1:0] itemsLeft,
  input  logic [6:0]       progLow,
  input  logic             progZero,
  output strobe_t          stb,
  output logic             streamOn,
  output logic             itemDone,
  output logic             tcFlag,
  output logic             errFlag,
  output logic             cfgErrFlag
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic onQ, tcQ, errQ, cfgErrQ;
  logic cfgWr, startReq, stopReq, legalNow, badWr, clrWr, cfgErrSet;
  cfg_t newCfg;

  always_comb begin
    newCfg   = cfgDecode(wrBits);
    cfgWr    = wrEn && (wrSel == SEL_CONFIG);
    startReq = cfgWr && !onQ && wrBits[0];
    stopReq  = cfgWr && onQ && !wrBits[0];
    legalNow = cfgLegal(newCfg, progLow, progZero);
    badWr    = onQ && wrEn &&
               (((wrSel == SEL_MBASE0) && !curTarget) ||
                ((wrSel == SEL_MBASE1) &&  curTarget));
    clrWr    = wrEn && (wrSel == SEL_FLAGCLR);
    cfgErrSet = startReq && !legalNow;

    stb.load    = startReq && legalNow;
    stb.step    = onQ && itemReq;
    stb.endXfer = onQ && itemReq && (itemsLeft == CNT_ONE);
    stb.reload  = modeCirc || modeDbl;
    stb.swap    = modeDbl;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      onQ     <= 1'b0;
      tcQ     <= 1'b0;
      errQ    <= 1'b0;
      cfgErrQ <= 1'b0;
    end else begin
      if (stb.load)
        onQ <= 1'b1;
      else if (badWr || stopReq || (stb.endXfer && !stb.reload))
        onQ <= 1'b0;

      if (stb.endXfer)               tcQ <= 1'b1;
      else if (clrWr && wrBits[0])   tcQ <= 1'b0;

      if (badWr)                     errQ <= 1'b1;
      else if (clrWr && wrBits[1])   errQ <= 1'b0;

      if (cfgErrSet)                 cfgErrQ <= 1'b1;
      else if (clrWr && wrBits[2])   cfgErrQ <= 1'b0;
    end
  end

  assign streamOn   = onQ;
  assign itemDone   = stb.step;
  assign tcFlag     = tcQ;
  assign errFlag    = errQ;
  assign cfgErrFlag = cfgErrQ;

endmodule

// File: rtl/dma_dbuf_dpath.sv
`timescale 1ns/1ps
module dma_dbuf_dpath
  import dma_dbuf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        wrSel,
  input  logic [ADDR_W-1:0] wrData,
  input  logic              streamOn,
  input  strobe_t           stb,
  output logic              modeCirc,
  output logic              modeDbl,
  output logic              curTarget,
  output logic [CNT_W-1:0]  itemsLeft,
  output logic [6:0]        progLow,
  output logic              progZero,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] perAddr
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  cfg_t              cfgQ;
  logic              ctQ;
  logic [CNT_W-1:0]  progQ, cntQ;
  logic [ADDR_W-1:0] perBase, mBase0, mBase1, memOff, perOff;
  logic [ADDR_W-1:0] memStep, perStep;
  logic              base0Ok, base1Ok;

  always_comb begin
    memStep = cfgQ.memInc ? {{(ADDR_W-3){1'b0}}, sizeBytes(cfgQ.memSize)} : '0;
    perStep = cfgQ.perInc ? {{(ADDR_W-3){1'b0}}, sizeBytes(cfgQ.perSize)} : '0;
    // a running stream may only retarget the idle base
    base0Ok = wrEn && (wrSel == SEL_MBASE0) && (!streamOn ||  ctQ);
    base1Ok = wrEn && (wrSel == SEL_MBASE1) && (!streamOn || !ctQ);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ    <= '0;
      ctQ     <= 1'b0;
      progQ   <= '0;
      cntQ    <= '0;
      perBase <= '0;
      mBase0  <= '0;
      mBase1  <= '0;
      memOff  <= '0;
      perOff  <= '0;
    end else begin
      if (wrEn && !streamOn) begin
        case (wrSel)
          SEL_CONFIG: begin
            cfgQ <= cfgDecode(wrData[13:0]);
            ctQ  <= wrData[3];
          end
          SEL_COUNT: begin
            progQ <= wrData[CNT_W-1:0];
            cntQ  <= wrData[CNT_W-1:0];
          end
          SEL_PADDR: perBase <= wrData;
          default: ;
        endcase
      end
      if (base0Ok) mBase0 <= wrData;
      if (base1Ok) mBase1 <= wrData;

      if (stb.load) begin
        cntQ   <= progQ;
        memOff <= '0;
        perOff <= '0;
      end else if (stb.step) begin
        if (stb.endXfer && stb.reload) begin
          cntQ   <= progQ;
          memOff <= '0;
          perOff <= '0;
          if (stb.swap) ctQ <= ~ctQ;
        end else begin
          cntQ   <= cntQ - CNT_ONE;
          memOff <= memOff + memStep;
          perOff <= perOff + perStep;
        end
      end
    end
  end

  assign modeCirc  = cfgQ.circ;
  assign modeDbl   = cfgQ.dbl;
  assign curTarget = ctQ;
  assign itemsLeft = cntQ;
  assign progLow   = progQ[6:0];
  assign progZero  = (progQ == '0);
  assign memAddr   = (ctQ ? mBase1 : mBase0) + memOff;
  assign perAddr   = perBase + perOff;

endmodule

// File: rtl/dma_dbuf_seq.sv
`timescale 1ns/1ps
module dma_dbuf_seq
  import dma_dbuf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        wrSel,
  input  logic [ADDR_W-1:0] wrData,
  input  logic              itemReq,
  output logic              itemDone,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] perAddr,
  output logic [CNT_W-1:0]  itemsLeft,
  output logic              curTarget,
  output logic              streamOn,
  output logic              tcFlag,
  output logic              errFlag,
  output logic              cfgErrFlag
);

  strobe_t    stb;
  logic       modeCirc, modeDbl, progZero;
  logic [6:0] progLow;

  dma_dbuf_ctrl #(.CNT_W(CNT_W)) ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrBits(wrData[13:0]),
    .itemReq(itemReq), .modeCirc(modeCirc), .modeDbl(modeDbl),
    .curTarget(curTarget), .itemsLeft(itemsLeft), .progLow(progLow),
    .progZero(progZero), .stb(stb), .streamOn(streamOn), .itemDone(itemDone),
    .tcFlag(tcFlag), .errFlag(errFlag), .cfgErrFlag(cfgErrFlag)
  );

  dma_dbuf_dpath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) dpath (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .streamOn(streamOn), .stb(stb), .modeCirc(modeCirc), .modeDbl(modeDbl),
    .curTarget(curTarget), .itemsLeft(itemsLeft), .progLow(progLow),
    .progZero(progZero), .memAddr(memAddr), .perAddr(perAddr)
  );

endmodule

// File: rtl/dma_dbuf_chk.sv
`timescale 1ns/1ps
module dma_dbuf_chk
  import dma_dbuf_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [2:0]       wrSel,
  input logic             itemDone,
  input logic             streamOn,
  input logic             curTarget,
  input logic [CNT_W-1:0] itemsLeft,
  input logic             modeCirc,
  input logic             modeDbl,
  input logic             progZero,
  input logic             tcFlag,
  input logic             errFlag,
  input logic             cfgErrFlag
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  // R3
  a_r3_done_needs_on: assert property (@(posedge clk) disable iff (!rstN)
    itemDone |-> streamOn);

  // R3
  a_r3_count_dec: assert property (@(posedge clk) disable iff (!rstN)
    (itemDone && itemsLeft > CNT_ONE && !wrEn) |=> (itemsLeft == $past(itemsLeft) - CNT_ONE));

  // R4
  a_r4_single_stop: assert property (@(posedge clk) disable iff (!rstN)
    (itemDone && itemsLeft == CNT_ONE && !modeCirc && !modeDbl) |=> (!streamOn && tcFlag));

  // R5
  a_r5_wrap_runs: assert property (@(posedge clk) disable iff (!rstN)
    (itemDone && itemsLeft == CNT_ONE && (modeCirc || modeDbl) && !wrEn)
      |=> (streamOn && tcFlag && !progZero));

  // R6
  a_r6_target_swap: assert property (@(posedge clk) disable iff (!rstN)
    (itemDone && itemsLeft == CNT_ONE && modeDbl) |=> (curTarget != $past(curTarget)));

  // R8
  a_r8_active_write: assert property (@(posedge clk) disable iff (!rstN)
    (streamOn && wrEn && ((wrSel == SEL_MBASE0 && !curTarget) ||
                          (wrSel == SEL_MBASE1 &&  curTarget)))
      |=> (errFlag && !streamOn));

  // R9
  a_r9_refused_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgErrFlag) |-> !streamOn);

endmodule

bind dma_dbuf_seq dma_dbuf_chk #(.CNT_W(CNT_W)) chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .itemDone(itemDone),
  .streamOn(streamOn), .curTarget(curTarget), .itemsLeft(itemsLeft),
  .modeCirc(modeCirc), .modeDbl(modeDbl), .progZero(progZero),
  .tcFlag(tcFlag), .errFlag(errFlag), .cfgErrFlag(cfgErrFlag)
);

// File: tb/dma_dbuf_seq_test.sv
`timescale 1ns/1ps
module dma_dbuf_seq_test;

  localparam int ADDR_W = 32;
  localparam int CNT_W  = 16;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrEn = 1'b0;
  logic [2:0]        wrSel = '0;
  logic [ADDR_W-1:0] wrData = '0;
  logic              itemReq = 1'b0;
  logic              itemDone, curTarget, streamOn, tcFlag, errFlag, cfgErrFlag;
  logic [ADDR_W-1:0] memAddr, perAddr;
  logic [CNT_W-1:0]  itemsLeft;

  always #10 clk = ~clk;

  dma_dbuf_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .itemReq(itemReq), .itemDone(itemDone), .memAddr(memAddr), .perAddr(perAddr),
    .itemsLeft(itemsLeft), .curTarget(curTarget), .streamOn(streamOn),
    .tcFlag(tcFlag), .errFlag(errFlag), .cfgErrFlag(cfgErrFlag)
  );

  int checks = 0;
  int fails  = 0;

  // bench model of the requirements
  bit bOn, bCirc, bDbl, bMi, bPi, bCt, bTc, bErr, bCfgErr;
  int bMs, bPs, bMb, bPb;
  int bProg, bCount;
  logic [31:0] bM0, bM1, bPer, bMemOff, bPerOff;

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int beatsOf(int e);
    return (e == 1) ? 4 : (e == 2) ? 8 : (e == 3) ? 16 : 1;
  endfunction

  function automatic int bytesOf(int e);
    return (e == 0) ? 1 : (e == 1) ? 2 : 4;
  endfunction

  function automatic bit legal(int ms, int ps, int mb, int pb, bit cyc, int n);
    if (ms == 3 || ps == 3 || n == 0) return 0;
    if (cyc) begin
      if (mb != 0 && (n % (beatsOf(mb) * bytesOf(ms) / bytesOf(ps))) != 0) return 0;
      if (pb != 0 && (n % (beatsOf(pb) * bytesOf(ps))) != 0) return 0;
    end
    return 1;
  endfunction

  function automatic logic [31:0] cfgWord(bit en, bit circ, bit dbl, bit ct, bit mi, bit pi,
                                          int ms, int ps, int mb, int pb);
    logic [1:0] a, b, c, d;
    a = ms[1:0]; b = ps[1:0]; c = mb[1:0]; d = pb[1:0];
    return {18'd0, d, c, b, a, pi, mi, ct, dbl, circ, en};
  endfunction

  function automatic logic [31:0] expMem();
    return (bCt ? bM1 : bM0) + bMemOff;
  endfunction

  task automatic wr(int sel, logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel[2:0]; wrData = d;
    @(posedge clk);
    #1 wrEn = 1'b0;
    case (sel)
      0: if (!bOn) begin
           bCirc = d[1]; bDbl = d[2]; bCt = d[3]; bMi = d[4]; bPi = d[5];
           bMs = int'(d[7:6]); bPs = int'(d[9:8]); bMb = int'(d[11:10]); bPb = int'(d[13:12]);
           if (d[0]) begin
             if (legal(bMs, bPs, bMb, bPb, bCirc || bDbl, bProg)) begin
               bOn = 1; bCount = bProg; bMemOff = 0; bPerOff = 0;
             end else bCfgErr = 1;
           end
         end else if (!d[0]) bOn = 0;
      1: if (!bOn) begin bProg = int'(d[15:0]); bCount = bProg; end
      2: if (!bOn) bPer = d;
      3: if (!bOn || bCt) bM0 = d; else begin bErr = 1; bOn = 0; end
      4: if (!bOn || !bCt) bM1 = d; else begin bErr = 1; bOn = 0; end
      5: begin if (d[0]) bTc = 0; if (d[1]) bErr = 0; if (d[2]) bCfgErr = 0; end
      default: ;
    endcase
  endtask

  task automatic modelStep();
    bTc = (bCount == 1) ? 1 : bTc;
    if (bCount == 1 && (bCirc || bDbl)) begin
      bCount = bProg; bMemOff = 0; bPerOff = 0;
      if (bDbl) bCt = !bCt;
    end else begin
      if (bCount == 1) bOn = 0;
      bCount = bCount - 1;
      bMemOff = bMemOff + (bMi ? bytesOf(bMs) : 0);
      bPerOff = bPerOff + (bPi ? bytesOf(bPs) : 0);
    end
  endtask

  task automatic item(string tag);
    @(negedge clk);
    itemReq = 1'b1;
    #2;
    check(tag, "itemDone", {31'd0, itemDone}, {31'd0, bOn});
    if (bOn) begin
      check(tag, "memAddr", memAddr, expMem());
      check(tag, "perAddr", perAddr, bPer + bPerOff);
    end
    @(posedge clk);
    #1 itemReq = 1'b0;
    if (bOn) modelStep();
  endtask

  task automatic idle();
    @(negedge clk);
    itemReq = 1'b0;
    #2 check("R3", "itemDone idle", {31'd0, itemDone}, 32'd0);
    @(posedge clk);
    #1;
  endtask

  task automatic checkState(string tag);
    check(tag, "streamOn",   {31'd0, streamOn},   {31'd0, bOn});
    check(tag, "itemsLeft",  {16'd0, itemsLeft},  bCount);
    check(tag, "curTarget",  {31'd0, curTarget},  {31'd0, bCt});
    check(tag, "tcFlag",     {31'd0, tcFlag},     {31'd0, bTc});
    check(tag, "errFlag",    {31'd0, errFlag},    {31'd0, bErr});
    check(tag, "cfgErrFlag", {31'd0, cfgErrFlag}, {31'd0, bCfgErr});
    check(tag, "memAddr",    memAddr,             expMem());
    check(tag, "perAddr",    perAddr,             bPer + bPerOff);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int seedDummy;
    seedDummy = int'($urandom(32'd20240611));
    bOn = 0; bCirc = 0; bDbl = 0; bMi = 0; bPi = 0; bCt = 0; bTc = 0; bErr = 0; bCfgErr = 0;
    bMs = 0; bPs = 0; bMb = 0; bPb = 0; bProg = 0; bCount = 0;
    bM0 = 0; bM1 = 0; bPer = 0; bMemOff = 0; bPerOff = 0;

    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    #2 checkState("R1");

    // R2 R4: single buffer, word memory increment, fixed peripheral
    wr(3, 32'h1000); wr(2, 32'h4000); wr(1, 3);
    wr(0, cfgWord(1, 0, 0, 0, 1, 0, 2, 1, 0, 0));
    checkState("R2");
    idle();
    item("R3"); item("R3");
    check("R3", "memAddr literal", memAddr, 32'h1008);
    item("R3");
    checkState("R4");
    check("R4", "streamOn literal", {31'd0, streamOn}, 32'd0);
    item("R4");
    wr(5, 32'h7);
    checkState("R13");

    // R6 R7 R8: double buffer with circular bit clear
    wr(3, 32'h2000); wr(4, 32'h3000); wr(2, 32'h5000); wr(1, 2);
    wr(0, cfgWord(1, 0, 1, 0, 1, 1, 1, 0, 0, 0));
    item("R6"); item("R6");
    checkState("R6");
    check("R6", "curTarget literal", {31'd0, curTarget}, 32'd1);
    wr(3, 32'h2800);
    checkState("R7");
    item("R6");
    check("R6", "perAddr after swap", perAddr, 32'h5001);
    item("R6");
    item("R7");
    check("R7", "new base used", memAddr, 32'h2802);
    wr(3, 32'h9000);
    checkState("R8");
    check("R8", "value discarded", memAddr, 32'h2802);
    item("R8");
    wr(5, 32'h7);

    // R5 R12: circular single target, ignored writes while running
    wr(3, 32'h6000); wr(2, 32'h7000); wr(1, 2);
    wr(0, cfgWord(1, 1, 0, 0, 1, 1, 0, 2, 0, 0));
    item("R5"); item("R5");
    checkState("R5");
    check("R5", "memAddr back to base", memAddr, 32'h6000);
    wr(1, 7); wr(2, 32'hABC0);
    wr(0, cfgWord(1, 0, 1, 1, 0, 0, 0, 0, 0, 0));
    checkState("R12");
    item("R12"); item("R12");
    check("R12", "count reload unchanged", {16'd0, itemsLeft}, 32'd2);
    wr(0, 32'd0);
    checkState("R12");
    wr(5, 32'h7);

    // R9: memory burst 8 beats, byte memory, half-word peripheral
    wr(1, 6);
    wr(0, cfgWord(1, 1, 0, 0, 1, 0, 0, 1, 2, 0));
    checkState("R9");
    check("R9", "refused start", {31'd0, streamOn}, 32'd0);
    wr(5, 32'h4);
    wr(1, 4);
    wr(0, cfgWord(1, 1, 0, 0, 1, 0, 0, 1, 2, 0));
    checkState("R9");
    wr(0, 32'd0);
    wr(1, 6);
    wr(0, cfgWord(1, 0, 0, 0, 1, 0, 0, 1, 2, 0));
    checkState("R9");
    wr(0, 32'd0);

    // R10: peripheral burst 4 beats of half-words
    wr(1, 12);
    wr(0, cfgWord(1, 1, 0, 0, 0, 1, 0, 1, 0, 1));
    checkState("R10");
    wr(5, 32'h4);
    wr(1, 16);
    wr(0, cfgWord(1, 1, 0, 0, 0, 1, 0, 1, 0, 1));
    checkState("R10");
    wr(0, 32'd0);

    // R11: zero count and reserved size
    wr(1, 0);
    wr(0, cfgWord(1, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    checkState("R11");
    wr(5, 32'h4);
    wr(1, 3);
    wr(0, cfgWord(1, 0, 0, 0, 1, 0, 3, 0, 0, 0));
    checkState("R11");

    // R13: selective clear
    wr(1, 1);
    wr(0, cfgWord(1, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    item("R13");
    wr(5, 32'h4);
    checkState("R13");
    wr(5, 32'h1);
    checkState("R13");

    // random configurations
    for (int it = 0; it < 40; it++) begin
      int ms, ps, mb, pb, mode, unit, cnt;
      bit cyc;
      if (bOn) wr(0, 32'd0);
      wr(5, 32'h7);
      ms = int'($urandom % 3); ps = int'($urandom % 3);
      mb = int'($urandom % 4); pb = int'($urandom % 4);
      mode = int'($urandom % 3);
      cyc = (mode != 0);
      unit = 1;
      if (cyc && mb != 0 && beatsOf(mb) * bytesOf(ms) / bytesOf(ps) > unit)
        unit = beatsOf(mb) * bytesOf(ms) / bytesOf(ps);
      if (cyc && pb != 0 && beatsOf(pb) * bytesOf(ps) > unit)
        unit = beatsOf(pb) * bytesOf(ps);
      cnt = cyc ? unit * (1 + int'($urandom % 3)) : 1 + int'($urandom % 6);
      if (cyc && unit > 1 && ($urandom % 5) == 0) cnt = cnt + 1;
      wr(1, cnt[31:0]); wr(2, $urandom); wr(3, $urandom); wr(4, $urandom);
      wr(0, cfgWord(1, mode == 1 || ($urandom % 2 == 1 && mode == 2), mode == 2,
                    $urandom % 2 == 1, $urandom % 2 == 1, $urandom % 2 == 1,
                    ms, ps, mb, pb));
      checkState("R2 R9 R10");
      for (int k = 0; k < 2 * cnt + 1; k++) begin
        if (($urandom % 4) == 0) idle();
        item("R3 R5 R6");
        if (bDbl && bOn && ($urandom % 8) == 0) wr(bCt ? 3 : 4, $urandom);
      end
      checkState("R4 R5 R6 R7");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule